// File: doc/BRIEF.md
# Character LCD Power-Up Initialisation Sequencer

This block sits between a host and a nibble write engine that drives a character LCD over a 4-bit bus. After a synchronous reset it takes the display from an unknown state to a known 4-bit configuration. The display may start in 8-bit mode, or in 4-bit mode with half a command already latched. The block first issues three single-strobe nibbles, each followed by its own settling gap. It then sends four full-byte configuration commands built from the static configuration inputs. When the last command has had its execution time, the block raises `init_done`.

From then on the host request stream passes straight through to the engine. Both the host side and the engine side use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. While the block is initialising, `host_ready` is held low, so the host is back-pressured and nothing it presents reaches the engine. Once `init_done` is high, `host_ready` follows `eng_ready` directly. The engine carries the back-pressure for every host byte.

All waits are parameters counted in clock cycles. Each gap is counted from the edge on which the engine accepts the transfer. The defaults suit a 50 MHz clock: a 15 ms power wait, 4.1 ms and 100 µs synchronisation gaps, a 50 µs command gap, and a 2.05 ms clear gap. Every wait parameter must be at least 1. The configuration inputs must be held stable while initialisation is in progress.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst` is high, and for exactly `T_POWER` cycles after it is released, `eng_valid`, `init_done` and `host_ready` are 0. At the end of that count `eng_valid` rises.
- R2: The first init transfer has `eng_byte` = 8'h30 with `eng_nibble_only` = 1, meaning only bits [7:4] are strobed once. It is followed by `T_SYNC_LONG` cycles with `eng_valid` low.
- R3: The second init transfer is again 8'h30 with `eng_nibble_only` = 1. It is followed by `T_SYNC_SHORT` cycles with `eng_valid` low.
- R4: The third init transfer is 8'h20 with `eng_nibble_only` = 1, which switches the display to 4-bit mode. It is followed by `T_CMD` cycles with `eng_valid` low.
- R5: The fourth transfer is a full byte (`eng_nibble_only` = 0) equal to {4'b0010, cfg_two_line, cfg_tall_font, 2'b00}. It is followed by `T_CMD` idle cycles.
- R6: The fifth transfer is the full byte {5'b00001, 1'b1, cfg_cursor, cfg_blink}, which turns the display on. It is followed by `T_CMD` idle cycles.
- R7: The sixth transfer is the full byte 8'h01 (clear). It is followed by `T_CLEAR` idle cycles.
- R8: The seventh transfer is the full byte {6'b000001, cfg_increment, cfg_shift}. After `T_CMD` further idle cycles `init_done` rises, and it stays high until reset.
- R9: An offered init transfer keeps `eng_valid` high and `eng_byte` and `eng_nibble_only` unchanged until `eng_ready` is high. Its gap starts at the acceptance edge.
- R10: Before `init_done`, `host_ready` is 0. `host_valid`, `host_rs` and `host_byte` have no effect on the engine outputs.
- R11: After `init_done`, `eng_valid`, `eng_rs` and `eng_byte` equal `host_valid`, `host_rs` and `host_byte` in the same cycle. `host_ready` equals `eng_ready`, and `eng_nibble_only` is 0.
- R12: Asserting `rst` at any point, during initialisation or after it, restarts the whole sequence from the power wait of R1.
- R13: Every init transfer has `eng_rs` = 0, and every nibble-only transfer has `eng_byte[3:0]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_two_line | input | 1 | Selects the two-line display mode |
| cfg_tall_font | input | 1 | Selects the 5x10 dot font |
| cfg_cursor | input | 1 | Shows the cursor |
| cfg_blink | input | 1 | Blinks the cursor position |
| cfg_increment | input | 1 | Address moves up after each write |
| cfg_shift | input | 1 | Shifts the display on each write |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted |
| host_rs | input | 1 | Host register select (0 command, 1 data) |
| host_byte | input | 8 | Host byte |
| eng_valid | output | 1 | Engine request valid |
| eng_ready | input | 1 | Engine accepts the request |
| eng_rs | output | 1 | Register select to the engine |
| eng_byte | output | 8 | Byte to the engine |
| eng_nibble_only | output | 1 | Strobe only bits [7:4], once |
| init_done | output | 1 | Initialisation complete |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of the sequence. Examples are a reset during a command gap while the engine is stalling, or a reset after `init_done` has risen. Either one must throw away a partly issued sequence and re-time the full power wait. The bench stalls `eng_ready` in several patterns so that offered transfers sit for many cycles. It then pulses `rst` at chosen points during initialisation and after completion. A behavioural queue model, compared on every clock, predicts the exact cycle of each transfer and of `init_done`. Throughout initialisation the host stream carries random traffic, so any leak through the blocked port would show up.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_ISSUE,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    GAP_CMD,
    GAP_SHORT,
    GAP_LONG,
    GAP_CLEAR
  } gap_sel_t;

  typedef struct packed {
    logic [7:0] code;
    logic       nib_only;
    gap_sel_t   gap;
  } init_xfer_t;

  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS + 1);

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_init_steps.sv
module lcd_init_steps
  import lcd_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              cfg_two_line,
  input  logic              cfg_tall_font,
  input  logic              cfg_cursor,
  input  logic              cfg_blink,
  input  logic              cfg_increment,
  input  logic              cfg_shift,
  output init_xfer_t        xfer
);

  always_comb begin
    xfer = '{code: 8'h00, nib_only: 1'b0, gap: GAP_CMD};
    case (step)
      STEP_W'(0): xfer = '{code: 8'h30, nib_only: 1'b1, gap: GAP_LONG};
      STEP_W'(1): xfer = '{code: 8'h30, nib_only: 1'b1, gap: GAP_SHORT};
      STEP_W'(2): xfer = '{code: 8'h20, nib_only: 1'b1, gap: GAP_CMD};
      STEP_W'(3): xfer = '{code: {4'b0010, cfg_two_line, cfg_tall_font, 2'b00},
                           nib_only: 1'b0, gap: GAP_CMD};
      STEP_W'(4): xfer = '{code: {5'b00001, 1'b1, cfg_cursor, cfg_blink},
                           nib_only: 1'b0, gap: GAP_CMD};
      STEP_W'(5): xfer = '{code: 8'h01, nib_only: 1'b0, gap: GAP_CLEAR};
      STEP_W'(6): xfer = '{code: {6'b000001, cfg_increment, cfg_shift},
                           nib_only: 1'b0, gap: GAP_CMD};
      default:    xfer = '{code: 8'h00, nib_only: 1'b0, gap: GAP_CMD};
    endcase
  end

endmodule

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_init_route.sv
module lcd_init_route (
  input  logic       done,
  input  logic       seq_valid,
  input  logic [7:0] seq_byte,
  input  logic       seq_nib,
  output logic       seq_ready,
  input  logic       host_valid,
  input  logic       host_rs,
  input  logic [7:0] host_byte,
  output logic       host_ready,
  input  logic       eng_ready,
  output logic       eng_valid,
  output logic       eng_rs,
  output logic [7:0] eng_byte,
  output logic       eng_nibble_only
);

  always_comb begin
    if (done) begin
      eng_valid       = host_valid;
      eng_rs          = host_rs;
      eng_byte        = host_byte;
      eng_nibble_only = 1'b0;
      host_ready      = eng_ready;
      seq_ready       = 1'b0;
    end else begin
      eng_valid       = seq_valid;
      eng_rs          = 1'b0;
      eng_byte        = seq_byte;
      eng_nibble_only = seq_nib;
      host_ready      = 1'b0;
      seq_ready       = eng_ready;
    end
  end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned T_POWER      = 750000,
  parameter int unsigned T_SYNC_LONG  = 205000,
  parameter int unsigned T_SYNC_SHORT = 5000,
  parameter int unsigned T_CMD        = 2500,
  parameter int unsigned T_CLEAR      = 102500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_two_line,
  input  logic       cfg_tall_font,
  input  logic       cfg_cursor,
  input  logic       cfg_blink,
  input  logic       cfg_increment,
  input  logic       cfg_shift,
  input  logic       host_valid,
  output logic       host_ready,
  input  logic       host_rs,
  input  logic [7:0] host_byte,
  output logic       eng_valid,
  input  logic       eng_ready,
  output logic       eng_rs,
  output logic [7:0] eng_byte,
  output logic       eng_nibble_only,
  output logic       init_done
);

  localparam int unsigned T_MAX = max2(max2(T_POWER, T_SYNC_LONG),
                                       max2(max2(T_SYNC_SHORT, T_CMD), T_CLEAR));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  seq_state_t        state_q;
  logic [STEP_W-1:0] step_q;
  init_xfer_t        xfer;
  logic              seq_ready;
  logic              accept;
  logic              tmr_load;
  logic              tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  gap_val;

  lcd_init_steps steps_i (
    .step          (step_q),
    .cfg_two_line  (cfg_two_line),
    .cfg_tall_font (cfg_tall_font),
    .cfg_cursor    (cfg_cursor),
    .cfg_blink     (cfg_blink),
    .cfg_increment (cfg_increment),
    .cfg_shift     (cfg_shift),
    .xfer          (xfer)
  );

  always_comb begin
    case (xfer.gap)
      GAP_LONG:  gap_val = CNT_W'(T_SYNC_LONG - 1);
      GAP_SHORT: gap_val = CNT_W'(T_SYNC_SHORT - 1);
      GAP_CLEAR: gap_val = CNT_W'(T_CLEAR - 1);
      default:   gap_val = CNT_W'(T_CMD - 1);
    endcase
  end

  assign accept   = (state_q == ST_ISSUE) && seq_ready;
  assign tmr_load = rst || accept;
  assign tmr_val  = rst ? CNT_W'(T_POWER - 1) : gap_val;

  lcd_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (tmr_expired) begin
            state_q <= (step_q == STEP_W'(NUM_STEPS)) ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (seq_ready) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign init_done = (state_q == ST_DONE);

  lcd_init_route route_i (
    .done            (init_done),
    .seq_valid       (state_q == ST_ISSUE),
    .seq_byte        (xfer.code),
    .seq_nib         (xfer.nib_only),
    .seq_ready       (seq_ready),
    .host_valid      (host_valid),
    .host_rs         (host_rs),
    .host_byte       (host_byte),
    .host_ready      (host_ready),
    .eng_ready       (eng_ready),
    .eng_valid       (eng_valid),
    .eng_rs          (eng_rs),
    .eng_byte        (eng_byte),
    .eng_nibble_only (eng_nibble_only)
  );

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_valid,
  input logic       host_ready,
  input logic       host_rs,
  input logic [7:0] host_byte,
  input logic       eng_valid,
  input logic       eng_ready,
  input logic       eng_rs,
  input logic [7:0] eng_byte,
  input logic       eng_nibble_only,
  input logic       init_done
);

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !host_ready); // R10

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
    (!init_done && eng_valid && !eng_ready) |=>
      (eng_valid && $stable(eng_byte) && $stable(eng_nibble_only))); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R8

  AST_INIT_RS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!init_done && eng_valid) |-> !eng_rs); // R13

  AST_NIBBLE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_nibble_only) |-> (eng_byte[3:0] == 4'h0)); // R13

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (eng_valid == host_valid && eng_rs == host_rs &&
                   eng_byte == host_byte && !eng_nibble_only &&
                   host_ready == eng_ready)); // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!init_done && !eng_valid)); // R12

endmodule

bind lcd_init_seq lcd_init_seq_chk chk_i (.*);

// File: tb/lcd_init_seq_tb_top.sv
module lcd_init_seq_tb_top;

  localparam int P = 20, L = 12, S = 5, C = 3, K = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_two_line = 0, cfg_tall_font = 0, cfg_cursor = 0;
  logic cfg_blink = 0, cfg_increment = 0, cfg_shift = 0;
  logic host_valid = 0, host_rs = 0, eng_ready = 0;
  logic [7:0] host_byte = 8'h00;
  logic host_ready, eng_valid, eng_rs, eng_nibble_only, init_done;
  logic [7:0] eng_byte;

  lcd_init_seq #(.T_POWER(P), .T_SYNC_LONG(L), .T_SYNC_SHORT(S),
                 .T_CMD(C), .T_CLEAR(K)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_two_line(cfg_two_line), .cfg_tall_font(cfg_tall_font),
    .cfg_cursor(cfg_cursor), .cfg_blink(cfg_blink),
    .cfg_increment(cfg_increment), .cfg_shift(cfg_shift),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_rs(host_rs), .host_byte(host_byte),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_rs(eng_rs),
    .eng_byte(eng_byte), .eng_nibble_only(eng_nibble_only),
    .init_done(init_done)
  );

  int total = 0, bad = 0, cyc = 0;
  bit mid_reset = 0;

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: queue of expected init transfers
  bit [7:0] q_byte[$];
  bit       q_nib[$];
  int       q_gap[$];
  string    q_tag[$];
  int       m_wait = P;
  bit       m_done = 0;
  string    m_gaptag = "R1";

  function automatic void push(bit [7:0] b, bit n, int g, string t);
    q_byte.push_back(b); q_nib.push_back(n); q_gap.push_back(g); q_tag.push_back(t);
  endfunction

  function automatic void build();
    q_byte.delete(); q_nib.delete(); q_gap.delete(); q_tag.delete();
    push(8'h30, 1, L, "R2");
    push(8'h30, 1, S, "R3");
    push(8'h20, 1, C, "R4");
    push({4'b0010, cfg_two_line, cfg_tall_font, 2'b00}, 0, C, "R5");
    push({5'b00001, 1'b1, cfg_cursor, cfg_blink}, 0, C, "R6");
    push(8'h01, 0, K, "R7");
    push({6'b000001, cfg_increment, cfg_shift}, 0, C, "R8");
  endfunction

  always @(posedge clk) begin
    bit ev_pre;
    bit ev;
    string tag;
    ev_pre = !m_done && m_wait == 0 && q_byte.size() > 0;
    if (rst) begin
      build();
      m_wait = P; m_done = 0; m_gaptag = "R1";
    end else if (!m_done) begin
      if (ev_pre && eng_ready) begin
        m_wait = q_gap[0]; m_gaptag = q_tag[0];
        void'(q_byte.pop_front()); void'(q_nib.pop_front());
        void'(q_gap.pop_front()); void'(q_tag.pop_front());
      end else if (m_wait > 0) begin
        m_wait--;
      end
      if (m_wait == 0 && q_byte.size() == 0) m_done = 1;
    end
    #5;
    ev = !m_done && m_wait == 0 && q_byte.size() > 0;
    if (!m_done) begin
      if (ev) tag = eng_ready ? q_tag[0] : "R9";
      else if (m_gaptag == "R1" && mid_reset) tag = "R12";
      else tag = m_gaptag;
      chk(tag, eng_valid, ev, "eng_valid");
      chk(tag, init_done, 0, "init_done");
      chk("R10", host_ready, 0, "host_ready");
      if (ev) begin
        chk(tag, eng_byte, q_byte[0], "eng_byte");
        chk(tag, eng_nibble_only, q_nib[0], "eng_nibble_only");
        chk("R13", eng_rs, 0, "eng_rs");
      end
    end else begin
      chk("R8", init_done, 1, "init_done");
      chk("R11", eng_valid, host_valid, "eng_valid");
      chk("R11", eng_byte, host_byte, "eng_byte");
      chk("R11", eng_rs, host_rs, "eng_rs");
      chk("R11", eng_nibble_only, 0, "eng_nibble_only");
      chk("R11", host_ready, eng_ready, "host_ready");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // mode 0: ready always; 1: random; 2: low three of every four cycles
  task automatic step_cycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: eng_ready = 1'b1;
        1: eng_ready = 1'($urandom % 2);
        default: eng_ready = ((cyc % 4) == 0);
      endcase
      host_valid = 1'($urandom % 2);
      host_rs    = 1'($urandom % 2);
      host_byte  = 8'($urandom);
    end
  endtask

  task automatic run_to_done(int mode);
    for (int i = 0; i < 1000 && !init_done; i++) step_cycles(1, mode);
  endtask

  task automatic do_reset(int n, bit mid);
    @(negedge clk);
    rst = 1'b1; mid_reset = mid;
    step_cycles(n, 1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // Run 1: two-line, increment, ready always high (R1..R8, R10, R11)
    {cfg_two_line, cfg_tall_font, cfg_cursor, cfg_blink, cfg_increment, cfg_shift} = 6'b100010;
    do_reset(3, 0);
    run_to_done(0);
    step_cycles(40, 1);
    // Run 2: other config, random stalls, reset mid-sequence (R9, R12)
    {cfg_two_line, cfg_tall_font, cfg_cursor, cfg_blink, cfg_increment, cfg_shift} = 6'b011101;
    do_reset(2, 0);
    step_cycles(45, 1);
    do_reset(2, 1);
    run_to_done(2);
    step_cycles(30, 1);
    // Run 3: all ones, reset after done restarts (R12)
    {cfg_two_line, cfg_tall_font, cfg_cursor, cfg_blink, cfg_increment, cfg_shift} = 6'b111111;
    do_reset(2, 0);
    run_to_done(1);
    step_cycles(10, 1);
    do_reset(1, 1);
    run_to_done(2);
    step_cycles(20, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule